// File: doc/BRIEF.md
# Bus Clock Divider Tree

This block turns one of two source-clock enables into three related bus clock enables (a fast bus enable, a mid-rate enable and a slow peripheral enable), all as single-cycle pulses in one fast clock domain. Both source clocks are modelled as enable strobes on the fast clock, so source selection is a plain multiplexer and needs no glitch-free switching.

A 16-bit configuration word selects the source and sets the division. The fast bus enable divides the chosen source. The two slower enables are counted in fast-bus pulses, so they only ever fire together with a fast-bus pulse. A parameter picks one of two decodes of the word. The linear style has a two-stage divide of the source and a mid ratio of 1, 2 or 4. The power-of-two style has a single source divide and ratio fields that are base-2 logarithms.

A written word is held as pending and switches in at the next fast-bus period boundary. A word that carries a reserved ratio code is dropped and reported on an error strobe.

Top module: `bus_clk_div_tree`

## Requirements
- R1: After reset all four outputs are low and the active setting is that of an all-zero word: source A is selected and every divide and ratio is 1.
- R2: Word bit 15 picks the source enable: 0 selects `src_a_en_i` and 1 selects `src_b_en_i`. The source that is not selected has no effect on any output.
- R3: With STYLE = DIV_LINEAR, one fast-bus period spans (word[7:3]+1)*(word[2:0]+1) enable cycles of the selected source.
- R4: With STYLE = DIV_POW2, one fast-bus period spans word[4:0]+1 enable cycles of the selected source.
- R5: With STYLE = DIV_LINEAR, word[9:8] sets fast-bus pulses per mid-rate pulse: code 0 gives 1, code 1 gives 2, code 3 gives 4, and code 2 is reserved.
- R6: With STYLE = DIV_LINEAR, word[14:12]+1 fast-bus pulses make one peripheral pulse.
- R7: With STYLE = DIV_POW2, the mid ratio is 2^word[9:8] for codes 0 to 2, with code 3 reserved. The peripheral ratio is 2^word[13:12] for codes 0 to 3.
- R8: The mid-rate and peripheral enables pulse only in cycles where the fast-bus enable pulses. Each fires on the first fast-bus pulse of its group, counted from the last setting change.
- R9: A valid word takes effect from the cycle after the first fast-bus tick at or after its write. Until then the old setting runs unchanged. A later valid write replaces a pending one.
- R10: A write carrying a reserved code raises `cfg_err_o` for exactly the next cycle and leaves both the active and the pending setting unchanged.
- R11: Each output is registered: a pulse appears one clock after the source-enable cycle that completes its period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_a_en_i | input | 1 | Enable strobe of source A (codec PLL side) |
| src_b_en_i | input | 1 | Enable strobe of source B (general PLL side) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_word_i | input | 16 | Configuration word |
| aclk_en_o | output | 1 | Fast-bus clock enable |
| hclk_en_o | output | 1 | Mid-rate clock enable |
| pclk_en_o | output | 1 | Peripheral clock enable |
| cfg_err_o | output | 1 | Reserved-code write strobe |

## Verification
The bench runs both styles side by side on the same stimulus. It targets the reserved codes, which differ between the two styles: a write that is reserved for one instance is legal for the other. If reserved words were not dropped, the mid ratio would drift and the pulse counts in fixed windows would not match. It targets writes that fall in the middle of a period: a design that applied a word at once would shorten or stretch that period and break the scoreboard. It also switches the source while the unselected enable keeps toggling, and it runs long windows of random enables and words. Such a window would show any mid or peripheral pulse that is out of step with the fast-bus enable, and any slip of the one-cycle output latency.

// File: rtl/bus_clk_div_pkg.sv
package bus_clk_div_pkg;

  localparam int CFG_W  = 16;
  localparam int PRE_W  = 3;
  localparam int MAIN_W = 5;
  localparam int RAT_W  = 3;
  localparam int SEL_BIT = CFG_W - 1;

  typedef enum logic {
    DIV_LINEAR = 1'b0,
    DIV_POW2   = 1'b1
  } div_style_e;

  typedef enum logic {
    HIT_AT_END   = 1'b0,
    HIT_AT_START = 1'b1
  } hit_align_e;

  // limits are terminal counts (ratio - 1)
  typedef struct packed {
    logic              src_sel;
    logic [PRE_W-1:0]  pre_lim;
    logic [MAIN_W-1:0] main_lim;
    logic [RAT_W-1:0]  h_lim;
    logic [RAT_W-1:0]  p_lim;
  } div_cfg_t;

endpackage

// File: rtl/bus_cfg_decode.sv
module bus_cfg_decode
  import bus_clk_div_pkg::*;
#(
  parameter div_style_e STYLE = DIV_LINEAR
) (
  input  logic [CFG_W-1:0] word_i,
  output div_cfg_t         cfg_o,
  output logic             bad_o
);

  generate
    if (STYLE == DIV_LINEAR) begin : g_linear
      logic [1:0] unused_bits;
      assign unused_bits = word_i[11:10];
      always_comb begin
        cfg_o.src_sel  = word_i[SEL_BIT];
        cfg_o.pre_lim  = word_i[2:0];
        cfg_o.main_lim = word_i[7:3];
        cfg_o.h_lim    = {1'b0, word_i[9:8]};
        cfg_o.p_lim    = word_i[14:12];
        bad_o          = (word_i[9:8] == 2'd2);
      end
    end else begin : g_pow2
      logic [4:0] unused_bits;
      assign unused_bits = {word_i[14], word_i[11:10], word_i[7:6]} == 5'd0 ? {4'd0, word_i[5]} : 5'd1;
      always_comb begin
        cfg_o.src_sel  = word_i[SEL_BIT];
        cfg_o.pre_lim  = '0;
        cfg_o.main_lim = word_i[4:0];
        cfg_o.h_lim    = RAT_W'((RAT_W'(1) << word_i[9:8]) - RAT_W'(1));
        cfg_o.p_lim    = RAT_W'((RAT_W'(1) << word_i[13:12]) - RAT_W'(1));
        bad_o          = (word_i[9:8] == 2'd3);
      end
    end
  endgenerate

endmodule

// File: rtl/bus_cfg_hold.sv
module bus_cfg_hold
  import bus_clk_div_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  div_cfg_t cfg_i,
  input  logic     bad_i,
  input  logic     boundary_i,
  output div_cfg_t act_o,
  output logic     reload_o,
  output logic     err_o
);

  div_cfg_t pend_q, act_q;
  logic     pend_v_q, err_q;

  assign reload_o = boundary_i && pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      act_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= we_i && bad_i;
      if (reload_o) act_q <= pend_q;
      if (we_i && !bad_i) begin
        pend_q   <= cfg_i;
        pend_v_q <= 1'b1;
      end else if (boundary_i) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  assign act_o = act_q;
  assign err_o = err_q;

endmodule

// File: rtl/bus_div_stage.sv
module bus_div_stage
  import bus_clk_div_pkg::*;
#(
  parameter int         W     = 3,
  parameter hit_align_e ALIGN = HIT_AT_END
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] lim_i,
  output logic         hit_o
);

  logic [W-1:0] cnt_q;
  logic         at_lim;

  assign at_lim = (cnt_q == lim_i);

  generate
    if (ALIGN == HIT_AT_END) begin : g_end
      assign hit_o = tick_i && at_lim;
    end else begin : g_start
      assign hit_o = tick_i && (cnt_q == '0);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= at_lim ? '0 : cnt_q + W'(1);
  end

endmodule

// File: rtl/bus_clk_div_tree.sv
module bus_clk_div_tree
  import bus_clk_div_pkg::*;
#(
  parameter div_style_e STYLE = DIV_LINEAR
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_a_en_i,
  input  logic             src_b_en_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_word_i,
  output logic             aclk_en_o,
  output logic             hclk_en_o,
  output logic             pclk_en_o,
  output logic             cfg_err_o
);

  localparam int N_RAT = 2;

  div_cfg_t   dec_cfg, act_cfg;
  logic       dec_bad, src_en, pre_tick, a_tick, reload;
  logic [RAT_W-1:0] rat_lim [N_RAT];
  logic [N_RAT-1:0] rat_hit;
  logic       aclk_q, hclk_q, pclk_q;

  bus_cfg_decode #(.STYLE(STYLE)) u_dec (
    .word_i (cfg_word_i),
    .cfg_o  (dec_cfg),
    .bad_o  (dec_bad)
  );

  bus_cfg_hold u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .cfg_i      (dec_cfg),
    .bad_i      (dec_bad),
    .boundary_i (a_tick),
    .act_o      (act_cfg),
    .reload_o   (reload),
    .err_o      (cfg_err_o)
  );

  assign src_en = act_cfg.src_sel ? src_b_en_i : src_a_en_i;

  bus_div_stage #(.W(PRE_W), .ALIGN(HIT_AT_END)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (reload),
    .tick_i (src_en),
    .lim_i  (act_cfg.pre_lim),
    .hit_o  (pre_tick)
  );

  bus_div_stage #(.W(MAIN_W), .ALIGN(HIT_AT_END)) u_main (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (reload),
    .tick_i (pre_tick),
    .lim_i  (act_cfg.main_lim),
    .hit_o  (a_tick)
  );

  assign rat_lim[0] = act_cfg.h_lim;
  assign rat_lim[1] = act_cfg.p_lim;

  // hclk / pclk count aclk ticks, fire on the first of each group
  for (genvar g = 0; g < N_RAT; g++) begin : g_rat
    bus_div_stage #(.W(RAT_W), .ALIGN(HIT_AT_START)) u_rat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (reload),
      .tick_i (a_tick),
      .lim_i  (rat_lim[g]),
      .hit_o  (rat_hit[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aclk_q <= 1'b0;
      hclk_q <= 1'b0;
      pclk_q <= 1'b0;
    end else begin
      aclk_q <= a_tick;
      hclk_q <= rat_hit[0];
      pclk_q <= rat_hit[1];
    end
  end

  assign aclk_en_o = aclk_q;
  assign hclk_en_o = hclk_q;
  assign pclk_en_o = pclk_q;

endmodule

// File: rtl/bus_clk_div_tree_chk.sv
module bus_clk_div_tree_chk
  import bus_clk_div_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     src_a_en_i,
  input logic     src_b_en_i,
  input logic     cfg_we_i,
  input logic     aclk_en_o,
  input logic     hclk_en_o,
  input logic     pclk_en_o,
  input logic     cfg_err_o,
  input div_cfg_t act_cfg,
  input logic     a_tick
);

  a_r8_hclk_on_aclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hclk_en_o |-> aclk_en_o);

  a_r8_pclk_on_aclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk_en_o |-> aclk_en_o);

  a_r10_err_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $past(cfg_we_i));

  a_r11_aclk_needs_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aclk_en_o |-> $past(src_a_en_i || src_b_en_i));

  a_r9_switch_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_cfg) |-> $past(a_tick));

  a_r11_aclk_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(a_tick) |-> aclk_en_o);

endmodule

bind bus_clk_div_tree bus_clk_div_tree_chk u_chk (.*);

// File: tb/bus_clk_div_tree_test.sv
module bus_clk_div_tree_test;
  import bus_clk_div_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni = 1'b0, sa = 1'b0, sb = 1'b0, we = 1'b0;
  logic [15:0] wd = '0;
  logic [1:0] ao, ho, po, eo;

  bus_clk_div_tree #(.STYLE(DIV_LINEAR)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .src_a_en_i(sa), .src_b_en_i(sb),
    .cfg_we_i(we), .cfg_word_i(wd),
    .aclk_en_o(ao[0]), .hclk_en_o(ho[0]), .pclk_en_o(po[0]), .cfg_err_o(eo[0]));

  bus_clk_div_tree #(.STYLE(DIV_POW2)) uut_p (
    .clk_i(clk), .rst_ni(rst_ni), .src_a_en_i(sa), .src_b_en_i(sb),
    .cfg_we_i(we), .cfg_word_i(wd),
    .aclk_en_o(ao[1]), .hclk_en_o(ho[1]), .pclk_en_o(po[1]), .cfg_err_o(eo[1]));

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { bit a, h, p, e; } exp_t;
  exp_t q0[$], q1[$];

  int na[2], nh[2], np[2], ne[2], n_orphan[2];

  // reference state, periods are counts (ratio), counters 0-based
  int m_sel[2], m_pre[2], m_mn[2], m_hr[2], m_pr[2];
  int c_pre[2], c_mn[2], c_h[2], c_p[2];
  bit m_pv[2];
  logic [15:0] m_pend[2];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic decode(int k, logic [15:0] w, output int s, output int pe,
                        output int m, output int h, output int p, output bit bad);
    s = int'(w[15]);
    bad = 0;
    if (k == 0) begin
      pe = int'(w[2:0]) + 1;
      m  = int'(w[7:3]) + 1;
      case (w[9:8])
        2'd0: h = 1;
        2'd1: h = 2;
        2'd3: h = 4;
        default: begin h = 2; bad = 1; end
      endcase
      p = int'(w[14:12]) + 1;
    end else begin
      pe = 1;
      m  = int'(w[4:0]) + 1;
      h  = 1 << w[9:8];
      bad = (w[9:8] == 2'd3);
      p  = 1 << w[13:12];
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      bit b;
      decode(k, 16'h0000, m_sel[k], m_pre[k], m_mn[k], m_hr[k], m_pr[k], b);
      c_pre[k] = 0; c_mn[k] = 0; c_h[k] = 0; c_p[k] = 0;
      m_pv[k] = 0; m_pend[k] = '0;
    end
  endtask

  task automatic model_eval(bit a, bit b, bit w, logic [15:0] d);
    for (int k = 0; k < 2; k++) begin
      exp_t e;
      bit src, pt, at, bad;
      int s, pe, m, h, p;
      src = (m_sel[k] != 0) ? b : a;
      pt  = src && (c_pre[k] == m_pre[k] - 1);
      at  = pt && (c_mn[k] == m_mn[k] - 1);
      decode(k, d, s, pe, m, h, p, bad);
      e.a = at;
      e.h = at && (c_h[k] == 0);
      e.p = at && (c_p[k] == 0);
      e.e = w && bad;
      if (k == 0) q0.push_back(e); else q1.push_back(e);
      if (src) c_pre[k] = pt ? 0 : c_pre[k] + 1;
      if (pt)  c_mn[k]  = at ? 0 : c_mn[k] + 1;
      if (at) begin
        c_h[k] = (c_h[k] == m_hr[k] - 1) ? 0 : c_h[k] + 1;
        c_p[k] = (c_p[k] == m_pr[k] - 1) ? 0 : c_p[k] + 1;
      end
      if (at && m_pv[k]) begin
        bit bb;
        decode(k, m_pend[k], m_sel[k], m_pre[k], m_mn[k], m_hr[k], m_pr[k], bb);
        c_pre[k] = 0; c_mn[k] = 0; c_h[k] = 0; c_p[k] = 0;
      end
      if (w && !bad) begin
        m_pend[k] = d;
        m_pv[k] = 1;
      end else if (at) begin
        m_pv[k] = 0;
      end
    end
  endtask

  task automatic step(bit a, bit b, bit w, logic [15:0] d);
    @(negedge clk);
    sa = a; sb = b; we = w; wd = d;
    @(posedge clk);
    model_eval(a, b, w, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 16'h0000);
  endtask

  // monitor: pop and compare each cycle
  always @(negedge clk) begin
    if (rst_ni) begin
      for (int k = 0; k < 2; k++) begin
        if ((k == 0 && q0.size() > 0) || (k == 1 && q1.size() > 0)) begin
          exp_t e;
          if (k == 0) e = q0.pop_front(); else e = q1.pop_front();
          chk(ao[k] == e.a, $sformatf("R3 R4 R9 R11 aclk inst%0d", k), ao[k], e.a);
          chk(ho[k] == e.h, $sformatf("R5 R7 R8 hclk inst%0d", k), ho[k], e.h);
          chk(po[k] == e.p, $sformatf("R6 R7 R8 pclk inst%0d", k), po[k], e.p);
          chk(eo[k] == e.e, $sformatf("R10 err inst%0d", k), eo[k], e.e);
          na[k] += ao[k]; nh[k] += ho[k]; np[k] += po[k]; ne[k] += eo[k];
          if ((ho[k] || po[k]) && !ao[k]) n_orphan[k]++;
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int sa0[2], sh0[2], sp0[2], se0[2];
    for (int k = 0; k < 2; k++) begin
      na[k] = 0; nh[k] = 0; np[k] = 0; ne[k] = 0; n_orphan[k] = 0;
    end
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int k = 0; k < 2; k++) begin
      chk(ao[k] == 0, "R1 aclk in reset", ao[k], 0);
      chk(ho[k] == 0 && po[k] == 0, "R1 hclk/pclk in reset", ho[k] | po[k], 0);
      chk(eo[k] == 0, "R1 err in reset", eo[k], 0);
    end
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 default: every source-A enable gives all three pulses
    for (int k = 0; k < 2; k++) begin sa0[k] = na[k]; sh0[k] = nh[k]; sp0[k] = np[k]; end
    for (int i = 0; i < 10; i++) step(1, 0, 0, 16'h0000);
    step(0, 1, 0, 16'h0000);
    idle(2);
    for (int k = 0; k < 2; k++) begin
      chk(na[k] - sa0[k] == 10, "R1 R2 default aclk count", na[k] - sa0[k], 10);
      chk(nh[k] - sh0[k] == 10 && np[k] - sp0[k] == 10, "R1 default hclk/pclk count",
          nh[k] - sh0[k], 10);
    end

    // select B, bus: pre 2 x main 4, h 2, p 2; pow2: main 26, h 2, p 2
    step(1, 0, 1, 16'h9119);
    step(1, 0, 0, 16'h0000);
    idle(2);
    for (int k = 0; k < 2; k++) begin sa0[k] = na[k]; sh0[k] = nh[k]; sp0[k] = np[k]; end
    for (int i = 0; i < 208; i++) step(0, 1, 0, 16'h0000);
    idle(2);
    chk(na[0] - sa0[0] == 26, "R3 linear aclk count", na[0] - sa0[0], 26);
    chk(nh[0] - sh0[0] == 13, "R5 linear hclk count", nh[0] - sh0[0], 13);
    chk(np[0] - sp0[0] == 13, "R6 linear pclk count", np[0] - sp0[0], 13);
    chk(na[1] - sa0[1] == 8,  "R4 pow2 aclk count", na[1] - sa0[1], 8);
    chk(nh[1] - sh0[1] == 4,  "R7 pow2 hclk count", nh[1] - sh0[1], 4);
    chk(np[1] - sp0[1] == 4,  "R7 pow2 pclk count", np[1] - sp0[1], 4);

    // R2: source A ignored while B selected
    for (int k = 0; k < 2; k++) sa0[k] = na[k];
    for (int i = 0; i < 40; i++) step(1, 0, 0, 16'h0000);
    idle(2);
    for (int k = 0; k < 2; k++)
      chk(na[k] - sa0[k] == 0, "R2 unselected source ignored", na[k] - sa0[k], 0);

    // R10: hclk code 2 reserved for linear, legal for pow2
    for (int k = 0; k < 2; k++) begin sa0[k] = na[k]; sh0[k] = nh[k]; se0[k] = ne[k]; end
    step(0, 1, 1, 16'h9219);
    for (int i = 0; i < 207; i++) step(0, 1, 0, 16'h0000);
    idle(2);
    chk(ne[0] - se0[0] == 1, "R10 linear reserved write flagged", ne[0] - se0[0], 1);
    chk(ne[1] - se0[1] == 0, "R10 pow2 legal write not flagged", ne[1] - se0[1], 0);
    chk(na[0] - sa0[0] == 26, "R10 linear aclk rate kept", na[0] - sa0[0], 26);
    chk(nh[0] - sh0[0] == 13, "R10 linear hclk ratio kept", nh[0] - sh0[0], 13);

    // R10: hclk code 3 reserved for pow2, legal for linear
    for (int k = 0; k < 2; k++) begin sa0[k] = na[k]; sh0[k] = nh[k]; se0[k] = ne[k]; end
    step(0, 1, 1, 16'h9319);
    for (int i = 0; i < 207; i++) step(0, 1, 0, 16'h0000);
    idle(2);
    chk(ne[0] - se0[0] == 0, "R10 linear legal write not flagged", ne[0] - se0[0], 0);
    chk(ne[1] - se0[1] == 1, "R10 pow2 reserved write flagged", ne[1] - se0[1], 1);
    chk(na[1] - sa0[1] == 8, "R10 pow2 aclk rate kept", na[1] - sa0[1], 8);
    chk(nh[1] - sh0[1] == 2, "R7 R10 pow2 hclk ratio 4 kept", nh[1] - sh0[1], 2);

    // R9: mid-period rewrites and random traffic, checked by scoreboard
    for (int i = 0; i < 5; i++) step(1, 1, 0, 16'h0000);
    step(1, 1, 1, 16'h0000);
    for (int i = 0; i < 12; i++) step(1, 1, 0, 16'h0000);
    for (int i = 0; i < 3000; i++) begin
      bit a, b, w;
      a = ($urandom % 4) != 0;
      b = ($urandom % 3) != 0;
      w = ($urandom % 50) == 0;
      step(a, b, w, 16'($urandom));
    end
    idle(2);
    for (int k = 0; k < 2; k++)
      chk(n_orphan[k] == 0, "R8 hclk/pclk without aclk", n_orphan[k], 0);

    finish_run();
  end

endmodule